// File: doc/BRIEF.md
# Self-timed SRAM access controller

This block is the control unit for a 1024-word by 16-bit synchronous static memory. Each rising edge of the access clock that arrives while the memory is selected produces one internal access pulse. The address, the write-enable and the write data are captured at that edge. While the pulse is high, the block drives one row enable, one column select and either a write strobe or a sense strobe.

The length of the pulse does not come from the access clock's high phase. A model of a replica bitline decides it. The model is precharged while no access is running and starts discharging when the pulse rises. Once it has discharged, the echo signal drops, and that low echo clears the access flip-flop. Clearing the flip-flop ends the pulse and shuts off the row.

Everything runs on a fast system clock `clk`. The access clock `acc_clk` is sampled on that clock, and the discharge time is a parameterised number of `clk` cycles. Read data from the array is captured in an output register when the echo drops. The register keeps that value until the next read completes.

Top module: `stc_ctrl`

## Requirements
- R1: When `cs_n` is high at a sampled rising edge of `acc_clk`, no pulse starts. While no pulse is active, `row_en`, `col_sel`, `wr_strobe` and `sense_en` are all zero.
- R2: A rising edge of `acc_clk` with `cs_n` low, seen at a `clk` edge while idle, raises `acc_pulse` after that edge. The same edge samples `addr`, `we` and `wdata`. During the pulse, `row_en` has exactly bit `addr[9:3]` set and `col_sel` has exactly bit `addr[2:0]` set.
- R3: During a write pulse (`we` = 1 when sampled), `wr_strobe` is high for the whole pulse and `arr_wdata` equals the sampled write data.
- R4: The dummy bitline model takes DISCHARGE_CYC `clk` edges after the pulse rises to discharge. `echo` is then low for exactly one cycle, and the next edge ends the pulse. The pulse therefore lasts DISCHARGE_CYC+1 cycles (5 by default) for any high time of `acc_clk`.
- R5: During a read pulse, `sense_en` is high only in the cycle where `echo` is low. At the edge that ends the pulse, `q` loads `arr_rdata`.
- R6: `q` keeps its value through write accesses, through idle cycles and through deselected clock edges.
- R7: A rising edge of `acc_clk` that arrives while a pulse is active is ignored and starts no second access.
- R8: A synchronous active-low `rst_n` clears the pulse, precharges the dummy bitline so that `echo` is high, and clears `q` to zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock |
| rst_n | input | 1 | Synchronous active-low reset |
| acc_clk | input | 1 | Access clock, sampled on clk |
| cs_n | input | 1 | Active-low chip select |
| we | input | 1 | 1 = write, 0 = read |
| addr | input | 10 | Word address, [9:3] row, [2:0] column |
| wdata | input | 16 | Write data |
| arr_rdata | input | 16 | Read data from the sense path |
| acc_pulse | output | 1 | Internal access pulse |
| echo | output | 1 | Dummy bitline echo, low when discharged |
| row_en | output | 128 | One-hot row enable, gated by the pulse |
| col_sel | output | 8 | One-hot column select, gated by the pulse |
| wr_strobe | output | 1 | Write drive enable |
| sense_en | output | 1 | Sense amplifier enable |
| arr_wdata | output | 16 | Captured write data to the array |
| q | output | 16 | Held read data |

## Verification
The pulse, `row_en` and `col_sel` change after the first `clk` edge that sees `acc_clk` high following a low sample. `echo` and `sense_en` change DISCHARGE_CYC edges after that. `q` and the falling pulse follow one edge later. The bench steps a behavioural model once per edge, using the inputs that were present at that edge. It compares every output 5 ns after each rising edge, so each result is checked in the cycle it is due.

// File: rtl/stc_pkg.sv
package stc_pkg;
    localparam int DEF_ADDR_W    = 10;
    localparam int DEF_DATA_W    = 16;
    localparam int DEF_COL_W     = 3;
    localparam int DEF_DISCHARGE = 4;
endpackage

// File: rtl/stc_onehot.sv
module stc_onehot #(
    parameter int IN_W = 3,
    localparam int OUT_N = 2 ** IN_W
) (
    input  logic             en,
    input  logic [IN_W-1:0]  sel,
    output logic [OUT_N-1:0] hot
);
    for (genvar i = 0; i < OUT_N; i++) begin : g_line
        assign hot[i] = en && (sel == IN_W'(i));
    end
endmodule

// File: rtl/stc_dummy_bl.sv
module stc_dummy_bl #(
    parameter int DISCHARGE_CYC = 4,
    localparam int CW = (DISCHARGE_CYC > 1) ? $clog2(DISCHARGE_CYC) : 1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic fire,
    output logic charged
);
    typedef struct packed {
        logic [CW-1:0] cnt;
        logic          high;
    } bl_t;

    bl_t s_d, s_q;

    always_comb begin
        s_d = s_q;
        if (!fire || !s_q.high) begin
            // precharge while idle, and at the edge the pulse is killed
            s_d.cnt  = '0;
            s_d.high = 1'b1;
        end else if (s_q.cnt == CW'(DISCHARGE_CYC - 1)) begin
            s_d.high = 1'b0;
        end else begin
            s_d.cnt = s_q.cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q.cnt  <= '0;
            s_q.high <= 1'b1;
        end else begin
            s_q <= s_d;
        end
    end

    assign charged = s_q.high;
endmodule

// File: rtl/stc_ctrl.sv
module stc_ctrl
    import stc_pkg::*;
#(
    parameter int ADDR_W        = DEF_ADDR_W,
    parameter int DATA_W        = DEF_DATA_W,
    parameter int COL_W         = DEF_COL_W,
    parameter int DISCHARGE_CYC = DEF_DISCHARGE,
    localparam int ROW_W = ADDR_W - COL_W,
    localparam int ROWS  = 2 ** ROW_W,
    localparam int COLS  = 2 ** COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              acc_clk,
    input  logic              cs_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    input  logic [DATA_W-1:0] arr_rdata,
    output logic              acc_pulse,
    output logic              echo,
    output logic [ROWS-1:0]   row_en,
    output logic [COLS-1:0]   col_sel,
    output logic              wr_strobe,
    output logic              sense_en,
    output logic [DATA_W-1:0] arr_wdata,
    output logic [DATA_W-1:0] q
);
    typedef struct packed {
        logic              pulse;
        logic              acc_prev;
        logic              we;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic [DATA_W-1:0] wdata;
        logic [DATA_W-1:0] q;
    } ctl_t;

    ctl_t s_d, s_q;
    logic bl_high;

    stc_dummy_bl #(.DISCHARGE_CYC(DISCHARGE_CYC)) u_dummy (
        .clk     (clk),
        .rst_n   (rst_n),
        .fire    (s_q.pulse),
        .charged (bl_high)
    );

    always_comb begin
        s_d          = s_q;
        s_d.acc_prev = acc_clk;
        if (!s_q.pulse) begin
            if (acc_clk && !s_q.acc_prev && !cs_n) begin
                s_d.pulse = 1'b1;
                s_d.we    = we;
                s_d.row   = addr[ADDR_W-1:COL_W];
                s_d.col   = addr[COL_W-1:0];
                s_d.wdata = wdata;
            end
        end else if (!bl_high) begin
            // low echo resets the access flip-flop
            s_d.pulse = 1'b0;
            if (!s_q.we) begin
                s_d.q = arr_rdata;
            end
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    stc_onehot #(.IN_W(ROW_W)) u_row_dec (
        .en  (s_q.pulse),
        .sel (s_q.row),
        .hot (row_en)
    );

    stc_onehot #(.IN_W(COL_W)) u_col_dec (
        .en  (s_q.pulse),
        .sel (s_q.col),
        .hot (col_sel)
    );

    assign acc_pulse = s_q.pulse;
    assign echo      = bl_high;
    assign wr_strobe = s_q.pulse && s_q.we;
    assign sense_en  = s_q.pulse && !s_q.we && !bl_high;
    assign arr_wdata = s_q.wdata;
    assign q         = s_q.q;
endmodule

// File: rtl/stc_ctrl_checks.sv
module stc_ctrl_checks #(
    parameter int ROWS   = 128,
    parameter int COLS   = 8,
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cs_n,
    input logic              acc_pulse,
    input logic              echo,
    input logic [ROWS-1:0]   row_en,
    input logic [COLS-1:0]   col_sel,
    input logic              wr_strobe,
    input logic              sense_en,
    input logic [DATA_W-1:0] q
);
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_pulse |-> (row_en == '0) && (col_sel == '0) && !wr_strobe && !sense_en);

    p_start_selected_r2: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(acc_pulse) |-> $past(!cs_n));

    p_row_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_pulse |-> $onehot(row_en) && $onehot(col_sel));

    p_row_steady_r2: assert property (@(posedge clk) disable iff (!rst_n)
        acc_pulse && $past(acc_pulse) |-> $stable(row_en) && $stable(col_sel));

    p_strobe_excl_r3: assert property (@(posedge clk) disable iff (!rst_n)
        wr_strobe |-> !sense_en);

    p_echo_kills_r4: assert property (@(posedge clk) disable iff (!rst_n)
        acc_pulse && !echo |=> !acc_pulse);

    p_echo_single_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !echo |=> echo);

    p_echo_idle_r4: assert property (@(posedge clk) disable iff (!rst_n)
        !acc_pulse |-> echo);

    p_sense_window_r5: assert property (@(posedge clk) disable iff (!rst_n)
        sense_en |-> !echo && acc_pulse);

    p_q_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !sense_en |=> $stable(q));

    p_reset_r8: assert property (@(posedge clk)
        !rst_n |=> !acc_pulse && echo && (q == '0));
endmodule

bind stc_ctrl stc_ctrl_checks #(
    .ROWS   (ROWS),
    .COLS   (COLS),
    .DATA_W (DATA_W)
) u_checks (
    .clk       (clk),
    .rst_n     (rst_n),
    .cs_n      (cs_n),
    .acc_pulse (acc_pulse),
    .echo      (echo),
    .row_en    (row_en),
    .col_sel   (col_sel),
    .wr_strobe (wr_strobe),
    .sense_en  (sense_en),
    .q         (q)
);

// File: tb/tb_stc_ctrl.sv
`timescale 1ns/1ps
module tb_stc_ctrl;
    localparam int D = 4;

    logic clk = 1'b0;
    always #10 clk = ~clk;

    logic         rst_n = 1'b0;
    logic         acc = 1'b0;
    logic         cs_n = 1'b1;
    logic         we = 1'b0;
    logic [9:0]   addr = '0;
    logic [15:0]  wdata = '0;
    logic [15:0]  arr_rdata;
    logic         acc_pulse, echo, wr_strobe, sense_en;
    logic [127:0] row_en;
    logic [7:0]   col_sel;
    logic [15:0]  arr_wdata, q;

    stc_ctrl dut (
        .clk(clk), .rst_n(rst_n), .acc_clk(acc), .cs_n(cs_n), .we(we),
        .addr(addr), .wdata(wdata), .arr_rdata(arr_rdata),
        .acc_pulse(acc_pulse), .echo(echo), .row_en(row_en), .col_sel(col_sel),
        .wr_strobe(wr_strobe), .sense_en(sense_en), .arr_wdata(arr_wdata), .q(q)
    );

    logic [15:0] mem [1024];
    int total = 0;
    int bad = 0;

    // bench-side array: addressed through the one-hot outputs
    function automatic int hot_addr(logic [127:0] r, logic [7:0] c);
        int ra = 0;
        int ca = 0;
        for (int i = 0; i < 128; i++) if (r[i]) ra = i;
        for (int j = 0; j < 8; j++) if (c[j]) ca = j;
        return ra * 8 + ca;
    endfunction

    always_comb begin
        if (row_en != '0) arr_rdata = mem[hot_addr(row_en, col_sel)];
        else arr_rdata = 16'h0000;
    end

    function automatic logic [15:0] pat(int a);
        return 16'((a * 40503) ^ 23100);
    endfunction

    task automatic chk(bit ok, string req, logic [127:0] act, logic [127:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s act=%h exp=%h at %0t", req, act, exp, $time);
        end
    endtask

    // reference model state
    bit          m_pulse = 0, m_prev = 0, m_we = 0;
    int          m_age = 0;
    logic [9:0]  m_a = '0;
    logic [15:0] m_wd = '0, m_q = '0;
    bit          prev_p = 0;
    int          wcnt = 0, last_w = 0, starts = 0;

    task automatic tick();
        logic [15:0] rd_pre = arr_rdata;
        bit          wr_pre = wr_strobe;
        logic [15:0] wd_pre = arr_wdata;
        int          a_pre = hot_addr(row_en, col_sel);
        logic [127:0] er;
        logic [7:0]   ec;
        bit           ee;
        @(posedge clk);
        #5;
        if (wr_pre) mem[a_pre] = wd_pre;
        if (!rst_n) begin
            m_pulse = 0; m_prev = 0; m_q = '0; m_age = 0;
        end else begin
            bit rise = acc && !m_prev;
            m_prev = acc;
            if (!m_pulse) begin
                if (rise && !cs_n) begin
                    m_pulse = 1; m_age = 0; m_we = we; m_a = addr; m_wd = wdata;
                end
            end else begin
                m_age++;
                if (m_age == D + 1) begin
                    m_pulse = 0;
                    if (!m_we) m_q = rd_pre;
                end
            end
        end
        er = m_pulse ? (128'd1 << m_a[9:3]) : '0;
        ec = m_pulse ? (8'd1 << m_a[2:0]) : '0;
        ee = !(m_pulse && m_age == D);
        chk(acc_pulse === m_pulse, "R2 pulse", 128'(acc_pulse), 128'(m_pulse));
        chk(row_en === er, "R2/R1 row_en", row_en, er);
        chk(col_sel === ec, "R2/R1 col_sel", 128'(col_sel), 128'(ec));
        chk(echo === ee, "R4 echo", 128'(echo), 128'(ee));
        chk(wr_strobe === (m_pulse && m_we), "R3 wr_strobe", 128'(wr_strobe), 128'(m_pulse && m_we));
        if (m_pulse && m_we) chk(arr_wdata === m_wd, "R3 arr_wdata", 128'(arr_wdata), 128'(m_wd));
        chk(sense_en === (m_pulse && !m_we && m_age == D), "R5 sense_en",
            128'(sense_en), 128'(m_pulse && !m_we && m_age == D));
        chk(q === m_q, "R6 q", 128'(q), 128'(m_q));
        if (acc_pulse && !prev_p) starts++;
        if (prev_p && !acc_pulse) last_w = wcnt;
        wcnt = acc_pulse ? (prev_p ? wcnt + 1 : 1) : 0;
        prev_p = acc_pulse;
    endtask

    task automatic access(bit c, bit w, int a, logic [15:0] d, int hi, int lo);
        cs_n = c; we = w; addr = 10'(a); wdata = d;
        acc = 1'b1;
        repeat (hi) tick();
        acc = 1'b0;
        repeat (lo) tick();
    endtask

    initial begin
        #(64'd200000 * 20);
        total++; bad++;
        $display("FAIL watchdog act=running exp=finished");
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        int s0;
        for (int i = 0; i < 1024; i++) mem[i] = '0;
        repeat (3) tick();
        rst_n = 1'b1;
        // R8: reset state
        chk(acc_pulse === 1'b0, "R8 pulse after reset", 128'(acc_pulse), 128'(0));
        chk(echo === 1'b1, "R8 echo after reset", 128'(echo), 128'(1));
        chk(q === 16'h0, "R8 q after reset", 128'(q), 128'(0));
        tick();

        // R1: deselected edges
        s0 = starts;
        repeat (3) access(1'b1, 1'b1, 77, 16'hBEEF, 5, 5);
        chk(starts == s0, "R1 no pulse when deselected", 128'(starts - s0), 128'(0));

        // R2, R3, R4: write all locations
        for (int a = 0; a < 1024; a++) begin
            access(1'b0, 1'b1, a, pat(a), 5, 5);
            if (a % 128 == 0)
                chk(last_w == D + 1 && last_w < 10, "R4 write pulse width", 128'(last_w), 128'(D + 1));
        end

        // R5: read all locations back
        for (int a = 0; a < 1024; a++) begin
            access(1'b0, 1'b0, a, 16'h0, 5, 5);
            chk(q === pat(a), "R5 read data", 128'(q), 128'(pat(a)));
            if (a % 128 == 1)
                chk(last_w == D + 1 && last_w < 10, "R4 read pulse width", 128'(last_w), 128'(D + 1));
        end

        // R4: long high phase does not stretch the pulse
        access(1'b0, 1'b0, 5, 16'h0, 9, 3);
        chk(last_w == D + 1, "R4 width with long high phase", 128'(last_w), 128'(D + 1));
        chk(q === pat(5), "R5 read addr 5", 128'(q), 128'(pat(5)));

        // R6: q holds over a write and idle time
        access(1'b0, 1'b1, 7, 16'h1234, 5, 5);
        chk(q === pat(5), "R6 q held over write", 128'(q), 128'(pat(5)));
        access(1'b1, 1'b0, 8, 16'h0, 5, 5);
        repeat (6) tick();
        chk(q === pat(5), "R6 q held over idle", 128'(q), 128'(pat(5)));
        access(1'b0, 1'b0, 7, 16'h0, 5, 5);
        chk(q === 16'h1234, "R5 read rewritten word", 128'(q), 128'h1234);

        // R7: second edge during active pulse ignored
        s0 = starts;
        access(1'b0, 1'b0, 9, 16'h0, 2, 1);
        access(1'b0, 1'b0, 10, 16'h0, 2, 1);
        repeat (4) tick();
        chk(starts - s0 == 1, "R7 overlapping edge ignored", 128'(starts - s0), 128'(1));
        chk(q === pat(9), "R7 first access data", 128'(q), 128'(pat(9)));

        // R8: reset in the middle of a pulse
        cs_n = 1'b0; we = 1'b0; addr = 10'd11; acc = 1'b1;
        repeat (2) tick();
        rst_n = 1'b0;
        tick();
        rst_n = 1'b1; acc = 1'b0;
        chk(acc_pulse === 1'b0, "R8 pulse cleared", 128'(acc_pulse), 128'(0));
        chk(echo === 1'b1, "R8 echo precharged", 128'(echo), 128'(1));
        chk(q === 16'h0, "R8 q cleared", 128'(q), 128'(0));
        repeat (3) tick();
        access(1'b0, 1'b0, 12, 16'h0, 5, 5);
        chk(q === pat(12), "R5 read after reset", 128'(q), 128'(pat(12)));

        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule